// File: doc/BRIEF.md
# Dual-Port Memory Row Transfer Controller

This block is the control core of a memory that has two ports: a random-access array and a serial register that streams one row of words. External strobes and control pins are sampled on the system clock. When the row strobe falls, the levels of the other pins decide what kind of cycle it is. A read transfer copies one whole array row into the serial register. A write transfer copies the serial register back into an array row, under a per-bit-plane mask. Any other pattern is an ordinary cycle, in which each fall of the column strobe reads or writes one word.

Both transfers take their row from the address bus at the row strobe fall. They take the starting column for the serial pointer from the address bus at the column strobe fall. When a transfer completes, the serial port changes direction. After a read transfer it shifts words out, one per rising edge of the serial clock. After a write transfer it accepts words in. A read transfer is committed only when the transfer enable returns high. Until then the previous row keeps streaming, so back-to-back rows can be sent with no gap.

Top module: `dpm_row_xfer`

## Requirements
- R1: After reset, `ser_dir` is 0 (input mode), `ser_dout` is 0 and `dq_out` is 0.
- R2: A row strobe fall with `xfer_oe_n` high starts an ordinary cycle. In it, each column strobe fall with `wr_en_n` low stores `dq_in` at the latched row and column. Each fall with `wr_en_n` high presents the stored word on `dq_out`.
- R3: A row strobe fall with `col_strb_n`=1, `xfer_oe_n`=0, `wr_en_n`=1 and `func_sel`=0 is a read transfer. When `xfer_oe_n` rises, the entire latched row is copied into the serial register and `ser_dir` becomes 1 (output).
- R4: The column on `addr` at the column strobe fall inside a transfer sets the serial pointer. In output mode, each serial clock rise puts the word at the pointer on `ser_dout` and advances the pointer by one. After the last column the pointer wraps to column 0.
- R5: Until `xfer_oe_n` rises, a pending read transfer leaves the serial register and pointer alone, and serial clocks keep shifting out the previous row.
- R6: With `func_sel`=1 at the row strobe fall, the read pin pattern is not a transfer. The serial register, the pointer and `ser_dir` keep their values.
- R7: A row strobe fall with `col_strb_n`=1, `xfer_oe_n`=0, `wr_en_n`=0 and `ser_en_n`=0 is a write transfer. When the row strobe rises, the serial register is written into the latched row, `ser_dir` becomes 0 (input) and the pointer is set to the latched column.
- R8: In a write transfer, bit b of `dq_in` sampled at the row strobe fall enables bit b of every word of the row when it is 1. When it is 0, that bit keeps its stored value.
- R9: With `ser_en_n`=1 at the row strobe fall, the write pin pattern is not a transfer, and the array row is not changed.
- R10: In input mode, each serial clock rise stores `ser_din` at the pointer and advances the pointer, with the same wrap as in R4.
- R11: Between the row strobe fall and rise of a write transfer, serial clock edges change neither the serial register nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| row_strb_n | input | 1 | Row strobe, active low |
| col_strb_n | input | 1 | Column strobe, active low |
| xfer_oe_n | input | 1 | Transfer enable, active low; its rise commits a read transfer |
| wr_en_n | input | 1 | Write enable, active low |
| func_sel | input | 1 | Function select; must be 0 for a read transfer |
| ser_en_n | input | 1 | Serial enable, active low; must be 0 for a write transfer |
| addr | input | ADDR_W | Multiplexed row / column address |
| dq_in | input | IO_W | Random-port write data, or the write transfer mask |
| dq_out | output | IO_W | Random-port read data (registered) |
| ser_clk | input | 1 | Serial clock; its rising edges shift the serial port |
| ser_din | input | IO_W | Serial input word |
| ser_dout | output | IO_W | Serial output word (registered) |
| ser_dir | output | 1 | Serial direction: 1 output, 0 input |

## Verification
The bench uses the default parameters: 4 bit planes, 16 rows and 16 columns. With 16 columns, a run of 17 serial clocks after one read transfer is enough to reach the pointer wrap. The 64-bit row is small enough to read back word by word through the random port after each write transfer. The 4 bit planes allow a mixed mask such as 0101, which shows bit by bit that enabled planes are taken from the serial register and disabled planes keep their old contents.

// File: rtl/dpm_xfer_pkg.sv
package dpm_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_RDX,
    ST_WRX,
    ST_DONE
  } xfer_state_t;

  typedef enum logic {
    SER_IN  = 1'b0,
    SER_OUT = 1'b1
  } ser_mode_t;

endpackage

// File: rtl/dpm_pin_ctrl.sv
module dpm_pin_ctrl
  import dpm_xfer_pkg::*;
#(
  parameter int ROW_AW = 4,
  parameter int COL_AW = 4,
  parameter int IO_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_strb_n,
  input  logic              col_strb_n,
  input  logic              xfer_oe_n,
  input  logic              wr_en_n,
  input  logic              func_sel,
  input  logic              ser_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   dq_in,
  output logic [ROW_AW-1:0] row_q,
  output logic [COL_AW-1:0] col_q,
  output logic [IO_W-1:0]   mask_q,
  output logic [IO_W-1:0]   data_q,
  output logic              rd_go,
  output logic              wr_go,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic              wr_hold
);

  // sampled pin levels and previous strobe levels
  logic              s_row, s_col, s_oe, s_we, s_fs, s_se;
  logic [ADDR_W-1:0] s_addr;
  logic [IO_W-1:0]   s_dq;
  logic              p_row, p_col, p_oe;
  logic              row_fall, row_rise, col_fall, oe_rise;
  logic              rd_hit, wr_hit;
  xfer_state_t       st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_row  <= 1'b1;
      s_col  <= 1'b1;
      s_oe   <= 1'b1;
      s_we   <= 1'b1;
      s_fs   <= 1'b0;
      s_se   <= 1'b1;
      s_addr <= '0;
      s_dq   <= '0;
      p_row  <= 1'b1;
      p_col  <= 1'b1;
      p_oe   <= 1'b1;
    end else begin
      s_row  <= row_strb_n;
      s_col  <= col_strb_n;
      s_oe   <= xfer_oe_n;
      s_we   <= wr_en_n;
      s_fs   <= func_sel;
      s_se   <= ser_en_n;
      s_addr <= addr;
      s_dq   <= dq_in;
      p_row  <= s_row;
      p_col  <= s_col;
      p_oe   <= s_oe;
    end
  end

  assign row_fall = p_row & ~s_row;
  assign row_rise = ~p_row & s_row;
  assign col_fall = p_col & ~s_col;
  assign oe_rise  = ~p_oe & s_oe;

  // cycle classification at the row strobe fall
  assign rd_hit = s_col & ~s_oe & s_we & ~s_fs;
  assign wr_hit = s_col & ~s_oe & ~s_we & ~s_se;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      mask_q <= '0;
      data_q <= '0;
      rd_go  <= 1'b0;
      wr_go  <= 1'b0;
      acc_wr <= 1'b0;
      acc_rd <= 1'b0;
    end else begin
      rd_go  <= 1'b0;
      wr_go  <= 1'b0;
      acc_wr <= 1'b0;
      acc_rd <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (row_fall) begin
            row_q <= s_addr[ROW_AW-1:0];
            col_q <= '0;
            if (rd_hit) begin
              st_q <= ST_RDX;
            end else if (wr_hit) begin
              st_q   <= ST_WRX;
              mask_q <= s_dq;
            end else begin
              st_q <= ST_ACC;
            end
          end
        end
        ST_RDX: begin
          if (col_fall) col_q <= s_addr[COL_AW-1:0];
          if (oe_rise) begin
            rd_go <= 1'b1;
            st_q  <= s_row ? ST_IDLE : ST_DONE;
          end
        end
        ST_WRX: begin
          if (col_fall) col_q <= s_addr[COL_AW-1:0];
          if (row_rise) begin
            wr_go <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_ACC: begin
          if (col_fall) begin
            col_q  <= s_addr[COL_AW-1:0];
            data_q <= s_dq;
            acc_wr <= ~s_we;
            acc_rd <= s_we;
          end
          if (row_rise) st_q <= ST_IDLE;
        end
        ST_DONE: begin
          if (row_rise) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_hold = (st_q == ST_WRX);

  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_go, wr_go, acc_wr, acc_rd}));

  // R3
  rd_go_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> $past(st_q) == ST_RDX);

  // R7
  wr_go_src_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> $past(st_q) == ST_WRX);

endmodule

// File: rtl/dpm_row_array.sv
module dpm_row_array #(
  parameter  int ROWS   = 16,
  parameter  int COLS   = 16,
  parameter  int IO_W   = 4,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int COL_AW = $clog2(COLS),
  localparam int ROW_W  = COLS * IO_W
) (
  input  logic              clk,
  input  logic [ROW_AW-1:0] row,
  input  logic [COL_AW-1:0] col,
  input  logic              row_wr,
  input  logic [ROW_W-1:0]  row_wdata,
  input  logic [IO_W-1:0]   row_mask,
  input  logic              word_wr,
  input  logic [IO_W-1:0]   word_wdata,
  input  logic              rd_en,
  output logic [ROW_W-1:0]  rd_data
);

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] bit_en;
  logic [ROW_W-1:0] wdat;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign bit_en[c*IO_W +: IO_W] = row_wr ? row_mask :
      ((col == COL_AW'(c)) ? {IO_W{1'b1}} : {IO_W{1'b0}});
    assign wdat[c*IO_W +: IO_W] = row_wr ? row_wdata[c*IO_W +: IO_W] : word_wdata;
  end

  always_ff @(posedge clk) begin
    if (row_wr || word_wr) begin
      mem[row] <= (mem[row] & ~bit_en) | (wdat & bit_en);
    end
    if (rd_en) begin
      rd_data <= mem[row];
    end
  end

endmodule

// File: rtl/dpm_serial_port.sv
module dpm_serial_port
  import dpm_xfer_pkg::*;
#(
  parameter  int COLS   = 16,
  parameter  int IO_W   = 4,
  localparam int COL_AW = $clog2(COLS),
  localparam int ROW_W  = COLS * IO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic [IO_W-1:0]   ser_din,
  input  logic              hold,
  input  logic              load_out,
  input  logic [ROW_W-1:0]  load_row,
  input  logic              set_in,
  input  logic [COL_AW-1:0] start_col,
  output logic [IO_W-1:0]   ser_dout,
  output logic              ser_dir,
  output logic [ROW_W-1:0]  sreg
);

  logic              s_sc, p_sc, sc_rise;
  logic [COL_AW-1:0] ptr_q, ptr_nxt;
  ser_mode_t         mode_q;

  assign sc_rise = s_sc & ~p_sc;
  assign ptr_nxt = (ptr_q == COL_AW'(COLS - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sc     <= 1'b0;
      p_sc     <= 1'b0;
      ptr_q    <= '0;
      sreg     <= '0;
      ser_dout <= '0;
      mode_q   <= SER_IN;
    end else begin
      s_sc <= ser_clk;
      p_sc <= s_sc;
      if (load_out) begin
        sreg   <= load_row;
        ptr_q  <= start_col;
        mode_q <= SER_OUT;
      end else if (set_in) begin
        ptr_q  <= start_col;
        mode_q <= SER_IN;
      end else if (sc_rise && !hold) begin
        if (mode_q == SER_OUT) begin
          ser_dout <= sreg[ptr_q*IO_W +: IO_W];
        end else begin
          sreg[ptr_q*IO_W +: IO_W] <= ser_din;
        end
        ptr_q <= ptr_nxt;
      end
    end
  end

  assign ser_dir = (mode_q == SER_OUT);

  // R11
  hold_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !load_out && !set_in) |=> (ptr_q == $past(ptr_q)) && $stable(sreg));

  // R3
  load_dir_chk: assert property (@(posedge clk) disable iff (rst)
    load_out |=> ser_dir);

  // R7
  set_in_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (set_in && !load_out) |=> !ser_dir);

endmodule

// File: rtl/dpm_row_xfer.sv
module dpm_row_xfer #(
  parameter  int ROWS   = 16,
  parameter  int COLS   = 16,
  parameter  int IO_W   = 4,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int COL_AW = $clog2(COLS),
  localparam int ADDR_W = (ROW_AW > COL_AW) ? ROW_AW : COL_AW,
  localparam int ROW_W  = COLS * IO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              row_strb_n,
  input  logic              col_strb_n,
  input  logic              xfer_oe_n,
  input  logic              wr_en_n,
  input  logic              func_sel,
  input  logic              ser_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   dq_in,
  output logic [IO_W-1:0]   dq_out,
  input  logic              ser_clk,
  input  logic [IO_W-1:0]   ser_din,
  output logic [IO_W-1:0]   ser_dout,
  output logic              ser_dir
);

  logic [ROW_AW-1:0] row_q;
  logic [COL_AW-1:0] col_q;
  logic [IO_W-1:0]   mask_q, data_q;
  logic              rd_go, wr_go, acc_wr, acc_rd, wr_hold;
  logic              rd_go_d, acc_rd_d;
  logic [ROW_W-1:0]  rd_q, sreg;

  dpm_pin_ctrl #(
    .ROW_AW (ROW_AW),
    .COL_AW (COL_AW),
    .IO_W   (IO_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .row_strb_n (row_strb_n),
    .col_strb_n (col_strb_n),
    .xfer_oe_n  (xfer_oe_n),
    .wr_en_n    (wr_en_n),
    .func_sel   (func_sel),
    .ser_en_n   (ser_en_n),
    .addr       (addr),
    .dq_in      (dq_in),
    .row_q      (row_q),
    .col_q      (col_q),
    .mask_q     (mask_q),
    .data_q     (data_q),
    .rd_go      (rd_go),
    .wr_go      (wr_go),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .wr_hold    (wr_hold)
  );

  dpm_row_array #(
    .ROWS (ROWS),
    .COLS (COLS),
    .IO_W (IO_W)
  ) u_array (
    .clk        (clk),
    .row        (row_q),
    .col        (col_q),
    .row_wr     (wr_go),
    .row_wdata  (sreg),
    .row_mask   (mask_q),
    .word_wr    (acc_wr),
    .word_wdata (data_q),
    .rd_en      (rd_go | acc_rd),
    .rd_data    (rd_q)
  );

  dpm_serial_port #(
    .COLS (COLS),
    .IO_W (IO_W)
  ) u_serial (
    .clk       (clk),
    .rst       (rst),
    .ser_clk   (ser_clk),
    .ser_din   (ser_din),
    .hold      (wr_hold),
    .load_out  (rd_go_d),
    .load_row  (rd_q),
    .set_in    (wr_go),
    .start_col (col_q),
    .ser_dout  (ser_dout),
    .ser_dir   (ser_dir),
    .sreg      (sreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_go_d  <= 1'b0;
      acc_rd_d <= 1'b0;
      dq_out   <= '0;
    end else begin
      rd_go_d  <= rd_go;
      acc_rd_d <= acc_rd;
      if (acc_rd_d) dq_out <= rd_q[col_q*IO_W +: IO_W];
    end
  end

endmodule

// File: tb/dpm_row_xfer_bench.sv
module dpm_row_xfer_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       row_strb_n, col_strb_n, xfer_oe_n, wr_en_n, func_sel, ser_en_n;
  logic [3:0] addr, dq_in, ser_din;
  logic       ser_clk;
  logic [3:0] dq_out, ser_dout;
  logic       ser_dir;

  int n_run  = 0;
  int n_fail = 0;

  logic [3:0] m_mem  [16][16];
  logic [3:0] m_sreg [16];
  int         m_ptr = 0;

  always #5 clk = ~clk;

  dpm_row_xfer u_dpm_row_xfer (
    .clk        (clk),
    .rst        (rst),
    .row_strb_n (row_strb_n),
    .col_strb_n (col_strb_n),
    .xfer_oe_n  (xfer_oe_n),
    .wr_en_n    (wr_en_n),
    .func_sel   (func_sel),
    .ser_en_n   (ser_en_n),
    .addr       (addr),
    .dq_in      (dq_in),
    .dq_out     (dq_out),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .ser_dout   (ser_dout),
    .ser_dir    (ser_dir)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic row_open(input logic [3:0] r, input logic oe, input logic we,
                          input logic fs, input logic se, input logic [3:0] mask);
    addr = r; xfer_oe_n = oe; wr_en_n = we; func_sel = fs; ser_en_n = se; dq_in = mask;
    tick(4);
    row_strb_n = 1'b0;
    tick(4);
  endtask

  task automatic col_pulse(input logic [3:0] c, input logic we, input logic [3:0] d);
    addr = c; wr_en_n = we; dq_in = d;
    tick(4);
    col_strb_n = 1'b0;
    tick(4);
    col_strb_n = 1'b1;
    tick(4);
  endtask

  task automatic row_close();
    row_strb_n = 1'b1;
    tick(4);
    xfer_oe_n = 1'b1; wr_en_n = 1'b1; func_sel = 1'b0; ser_en_n = 1'b1;
    tick(4);
  endtask

  task automatic fill_row(input int r);
    row_open(4'(r), 1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
    for (int c = 0; c < 16; c++) begin
      col_pulse(4'(c), 1'b0, 4'((r * 7 + c * 3 + 1) & 15));
      m_mem[r][c] = 4'((r * 7 + c * 3 + 1) & 15);
    end
    row_close();
  endtask

  task automatic read_chk(input string req, input int r, input int c);
    row_open(4'(r), 1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
    col_pulse(4'(c), 1'b1, 4'h0);
    chk(req, 8'(dq_out), 8'(m_mem[r][c]));
    row_close();
  endtask

  task automatic sclk_pulse(input logic [3:0] d);
    ser_din = d;
    tick(4);
    ser_clk = 1'b1;
    tick(4);
    ser_clk = 1'b0;
    tick(4);
  endtask

  task automatic sclk_out_chk(input string req);
    logic [3:0] exp;
    exp = m_sreg[m_ptr];
    sclk_pulse(4'h0);
    chk(req, 8'(ser_dout), 8'(exp));
    m_ptr = (m_ptr + 1) % 16;
  endtask

  task automatic sclk_in(input logic [3:0] d);
    sclk_pulse(d);
    m_sreg[m_ptr] = d;
    m_ptr = (m_ptr + 1) % 16;
  endtask

  task automatic model_load(input int r, input int c);
    for (int k = 0; k < 16; k++) m_sreg[k] = m_mem[r][k];
    m_ptr = c;
  endtask

  task automatic model_wr(input int r, input int c, input logic [3:0] mask);
    for (int k = 0; k < 16; k++) m_mem[r][k] = (m_mem[r][k] & ~mask) | (m_sreg[k] & mask);
    m_ptr = c;
  endtask

  task automatic read_xfer(input int r, input int c);
    row_open(4'(r), 1'b0, 1'b1, 1'b0, 1'b1, 4'h0);
    col_pulse(4'(c), 1'b1, 4'h0);
    xfer_oe_n = 1'b1;
    tick(4);
    row_close();
    model_load(r, c);
  endtask

  task automatic write_xfer(input int r, input int c, input logic [3:0] mask);
    row_open(4'(r), 1'b0, 1'b0, 1'b0, 1'b0, mask);
    col_pulse(4'(c), 1'b0, 4'h0);
    row_close();
    model_wr(r, c, mask);
  endtask

  task automatic t_reset();
    chk("R1 dir", 8'(ser_dir), 8'h0);
    chk("R1 sout", 8'(ser_dout), 8'h0);
    chk("R1 dout", 8'(dq_out), 8'h0);
  endtask

  task automatic t_access();
    fill_row(2); fill_row(5); fill_row(9); fill_row(10);
    read_chk("R2 r2c0", 2, 0);
    read_chk("R2 r2c15", 2, 15);
    read_chk("R2 r5c7", 5, 7);
    row_open(4'd10, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
    col_pulse(4'd3, 1'b0, 4'hE);
    m_mem[10][3] = 4'hE;
    col_pulse(4'd3, 1'b1, 4'h0);
    chk("R2 same-page reread", 8'(dq_out), 8'hE);
    row_close();
  endtask

  task automatic t_read_xfer();
    read_xfer(2, 3);
    chk("R3 dir out", 8'(ser_dir), 8'h1);
    for (int k = 0; k < 17; k++) sclk_out_chk("R3/R4 stream with wrap");
  endtask

  task automatic t_realtime();
    row_open(4'd5, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0);
    col_pulse(4'd0, 1'b1, 4'h0);
    sclk_out_chk("R5 old row before commit");
    sclk_out_chk("R5 old row before commit");
    xfer_oe_n = 1'b1;
    tick(4);
    row_close();
    model_load(5, 0);
    for (int k = 0; k < 3; k++) sclk_out_chk("R5 new row after commit");
  endtask

  task automatic t_func_sel();
    row_open(4'd9, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
    row_close();
    chk("R6 dir kept", 8'(ser_dir), 8'h1);
    sclk_out_chk("R6 stream continues");
    sclk_out_chk("R6 stream continues");
  endtask

  task automatic t_write_xfer();
    write_xfer(9, 0, 4'b0000);
    chk("R7 dir in", 8'(ser_dir), 8'h0);
    read_chk("R8 zero mask keeps c0", 9, 0);
    read_chk("R8 zero mask keeps c8", 9, 8);
    for (int k = 0; k < 16; k++) sclk_in(4'(k) ^ 4'hA);
    write_xfer(9, 5, 4'b1111);
    read_chk("R7 full row c0", 9, 0);
    read_chk("R7 full row c7", 9, 7);
    read_chk("R7 full row c15", 9, 15);
    for (int k = 0; k < 16; k++) sclk_in(4'((k * 5 + 2) & 15));
    write_xfer(10, 0, 4'b0101);
    for (int c = 0; c < 16; c++) read_chk("R8/R10 masked planes", 10, c);
  endtask

  task automatic t_ignore_se();
    row_open(4'd10, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
    row_close();
    read_chk("R9 row kept c1", 10, 1);
    read_chk("R9 row kept c6", 10, 6);
    chk("R9 dir kept", 8'(ser_dir), 8'h0);
  endtask

  task automatic t_hold();
    row_open(4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF);
    sclk_pulse(4'hF);
    sclk_pulse(4'hF);
    col_pulse(4'd0, 1'b0, 4'h0);
    row_close();
    model_wr(2, 0, 4'hF);
    for (int c = 0; c < 4; c++) read_chk("R11 clocks ignored while pending", 2, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    row_strb_n = 1'b1; col_strb_n = 1'b1; xfer_oe_n = 1'b1; wr_en_n = 1'b1;
    func_sel = 1'b0; ser_en_n = 1'b1; addr = '0; dq_in = '0;
    ser_clk = 1'b0; ser_din = '0;
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_access();
    t_read_xfer();
    t_realtime();
    t_func_sel();
    t_write_xfer();
    t_ignore_se();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule